// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks, from eight interrupt request lines, the one that should be presented to the processor next. Its inputs are the pending requests, a mask, the lines already in service, a 3-bit rotation base and a special-nesting enable. Priority is counted from the rotation base. The line at the base has the highest priority, and the positions that follow it, wrapping round, have lower priority. This lets the lowest-priority position move as the base changes.

A pending, unmasked request is presented only if it strictly outranks every line currently in service. When special nesting is enabled on the primary controller of a cascade, the in-service bit of the cascade input is left out of that comparison. The decision is registered once, so the result appears one clock after the inputs are sampled. Updating the rotation base and setting or clearing in-service bits are the job of the surrounding controller.

Top module: `rot_prio_resolver`

## Requirements
- R1: Rank k (0 highest, 7 lowest) belongs to line (k + rot) mod 8. Among pending, unmasked lines the one of lowest rank wins, and `irq_line` reports its line number (rank + rot) mod 8, wrapping past line 7 to line 0.
- R2: A line whose bit in `mask` is 1 takes no part in selection, whatever its pending bit.
- R3: When no line is both pending and unmasked, `irq_valid` is 0 and `irq_line` is 0.
- R4: The in-service rank is the lowest rank among set `insvc` bits, using the same rotation, or 8 when none is set. `irq_valid` is 1 only when the request rank is strictly less than the in-service rank; a request of equal or lower priority yields `irq_valid` 0 and `irq_line` 0.
- R5: With no in-service bit set, any pending unmasked request is presented.
- R6: When `nest_en` and `primary` are both 1, `insvc` bit 2 (the cascade input) is ignored in the in-service rank. If either of them is 0, bit 2 counts like any other bit.
- R7: Outputs are registered. They reflect the inputs present at the previous rising edge of `clk` and do not change between edges. While `rst_n` is 0, `irq_valid` and `irq_line` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | 8 | Pending request bits, one per line |
| mask | input | 8 | Mask bits; 1 blocks the line |
| insvc | input | 8 | In-service bits, one per line |
| rot | input | 3 | Rotation base: the line holding rank 0 |
| nest_en | input | 1 | Special-nesting enable |
| primary | input | 1 | 1 when this instance is the primary of a cascade |
| irq_valid | output | 1 | An interrupt should be signalled |
| irq_line | output | 3 | Winning line number, 0 when not valid |

## Verification
The bench sets the rotation base so that the winning line lies past line 7. A design that took the line as the rank alone, or that failed to wrap, would then report the wrong line. Equal-rank cases, where the request line is itself in service, catch a non-strict comparison that would re-signal a line already being handled. The special-nesting cases switch `nest_en` and `primary` one at a time, and one case has the cascade line both pending and in service. Together they catch a design that drops bit 2 unconditionally or never drops it. Masked-only and empty request patterns check that the index is forced to 0, and probes taken between clock edges check that nothing leaks through combinationally.

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int LINES   = 8,
  parameter int CASCADE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         pend,
  input  logic [LINES-1:0]         mask,
  input  logic [LINES-1:0]         insvc,
  input  logic [$clog2(LINES)-1:0] rot,
  input  logic                     nest_en,
  input  logic                     primary,
  output logic                     irq_valid,
  output logic [$clog2(LINES)-1:0] irq_line
);
  localparam int IW = $clog2(LINES);
  localparam int RW = IW + 1;
  localparam logic [RW-1:0] NONE = RW'(LINES);

  function automatic logic [RW-1:0] top_rank(input logic [LINES-1:0] bits,
                                             input logic [IW-1:0] base);
    logic [RW-1:0] r;
    r = NONE;
    for (int k = LINES - 1; k >= 0; k--)
      if (bits[IW'(k) + base]) r = RW'(k);
    return r;
  endfunction

  logic [LINES-1:0] req_bits, isr_bits;
  logic [RW-1:0]    req_rank, isr_rank;
  logic             win;

  assign req_bits = pend & ~mask;
  assign isr_bits = (nest_en && primary) ? (insvc & ~(LINES'(1) << CASCADE)) : insvc;
  assign req_rank = top_rank(req_bits, rot);
  assign isr_rank = top_rank(isr_bits, rot);
  assign win      = (req_rank != NONE) && (req_rank < isr_rank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_line  <= '0;
    end else begin
      irq_valid <= win;
      irq_line  <= win ? (IW'(req_rank) + rot) : '0;
    end
  end
endmodule

// File: rtl/rot_prio_resolver_chk.sv
module rot_prio_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pend,
  input logic [7:0] mask,
  input logic [7:0] insvc,
  input logic [2:0] rot,
  input logic       nest_en,
  input logic       primary,
  input logic       irq_valid,
  input logic [2:0] irq_line
);
  a_r1_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((($past(pend & ~mask) >> irq_line) & 8'h01) != 8'h00));

  a_r3_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_line == 3'd0);

  a_r3_no_request_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend & ~mask) == 8'h00) |-> !irq_valid);

  a_r4_winner_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !($past(nest_en && primary) && irq_line == 3'd2))
      |-> ((($past(insvc) >> irq_line) & 8'h01) == 8'h00));

  a_r4_top_rank_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (((($past(insvc) >> $past(rot)) & 8'h01) != 8'h00)
      && !($past(nest_en && primary) && $past(rot) == 3'd2)) |-> !irq_valid);

  a_r7_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (!irq_valid && irq_line == 3'd0));
endmodule

bind rot_prio_resolver rot_prio_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .insvc(insvc),
  .rot(rot), .nest_en(nest_en), .primary(primary),
  .irq_valid(irq_valid), .irq_line(irq_line)
);

// File: tb/rot_prio_resolver_test.sv
`timescale 1ns/1ps
module rot_prio_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend = 8'h00, mask = 8'h00, insvc = 8'h00;
  logic [2:0] rot = 3'd0;
  logic       nest_en = 1'b0, primary = 1'b0;
  logic       irq_valid;
  logic [2:0] irq_line;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rot_prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .insvc(insvc),
    .rot(rot), .nest_en(nest_en), .primary(primary),
    .irq_valid(irq_valid), .irq_line(irq_line)
  );

  // {req, pend, mask, insvc, rot, nest_en, primary, exp_valid, exp_line}
  localparam int NV = 19;
  localparam logic [36:0] VEC [NV] = '{
    {4'd1, 8'h28, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd3},
    {4'd1, 8'h28, 8'h00, 8'h00, 3'd4, 1'b0, 1'b0, 1'b1, 3'd5},
    {4'd1, 8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7},
    {4'd1, 8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},
    {4'd1, 8'h03, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, 3'd0},
    {4'd2, 8'h28, 8'h08, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd5},
    {4'd2, 8'hFF, 8'hFE, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, 3'd0},
    {4'd3, 8'h28, 8'h28, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd3, 8'h00, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd4, 8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd4, 8'h08, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b1, 3'd3},
    {4'd4, 8'h10, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd4, 8'h01, 8'h00, 8'h80, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},
    {4'd4, 8'h01, 8'h00, 8'h80, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0},
    {4'd5, 8'hFF, 8'h00, 8'h00, 3'd6, 1'b0, 1'b0, 1'b1, 3'd6},
    {4'd6, 8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1, 3'd3},
    {4'd6, 8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0},
    {4'd6, 8'h08, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0},
    {4'd6, 8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1, 3'd2}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic v, input logic [2:0] l);
    checks++;
    if (irq_valid !== v || irq_line !== l) begin
      fails++;
      $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
               req, irq_valid, irq_line, v, l);
    end
  endtask

  initial begin
    #20000;
    fails++;
    checks++;
    $display("FAIL R7: watchdog expired, got no end, expected end of run");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    pend = 8'hFF;
    repeat (2) @(negedge clk);
    check("R7", 1'b0, 3'd0); // reset holds outputs low despite requests
    rst_n = 1'b1;
    pend = 8'h00;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {pend, mask, insvc, rot, nest_en, primary} = VEC[i][32:4];
      @(negedge clk);
      check(tag(VEC[i][36:33]), VEC[i][3], VEC[i][2:0]);
    end

    // R7: new inputs do not reach the outputs before the next edge
    pend = 8'h00; mask = 8'h00; insvc = 8'h00; rot = 3'd0;
    nest_en = 1'b0; primary = 1'b0;
    @(negedge clk);
    pend = 8'h40;
    #1;
    check("R7", 1'b0, 3'd0);
    @(negedge clk);
    check("R7", 1'b1, 3'd6);

    // R7: asynchronous reset clears a valid output mid-run
    rst_n = 1'b0;
    #1;
    check("R7", 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", 1'b1, 3'd6);

    // R2: masking the only request withdraws it on the next edge
    mask = 8'h40;
    @(negedge clk);
    check("R2", 1'b0, 3'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule